// File: doc/BRIEF.md
# Frequency-Mode System Counter

This block keeps a free-running 64-bit time base for a chip's timers. On each base clock cycle, while counting is switched on, it adds an increment taken from the active entry of a small frequency-mode table. A slower mode with a larger step therefore still tracks wall-clock time. Downstream timers receive the count, the active frequency value and the index of the active table entry directly on output ports.

Software controls the block through a word-addressed register port. Through it, software switches counting on and off, loads the count while counting is off, fills the mode table and asks for a switch to another mode. The switch takes effect on the clock after the request. At that moment the count is first realigned to the larger of the old and new step, so that it stays a multiple-friendly value for the new step. A second pair of offsets gives a read-only view of the count.

Top module: `tick_base_counter`

## Requirements
- R1: The count changes only while the run bit (control word at offset 0, bit 0) is 1, apart from direct loads and mode switches; while the run bit is 0 the count holds its value.
- R2: The mode table has DEPTH positions, at most 1004. Positions 0 to DEPTH-2 are words at offsets 16+i, with the frequency in bits [31:8] and the step in bits [7:0]. Position DEPTH-1 is a terminator: it reads as zero, ignores writes, and a switch request naming it or any higher index is ignored.
- R3: A control write with bit 3 set and a target index in bits [31:16] requests a mode switch. On the next clock, entry_o, freq_o and the status word (offset 1, index in bits [31:16]) show the new entry. Until then, status bit 0 shows the request as pending.
- R4: When a switch takes effect, the count becomes count + (count mod max(old step, new step)), no step is added on that clock, and the new step applies from the following clock.
- R5: On every clock with the run bit set, the count grows by the step of the active entry, carrying across the 32-bit boundary.
- R6: While counting is off, a write to offset 2 replaces the low word of the count and a write to offset 3 replaces the high word; the new value is visible after the write clock.
- R7: Offsets 8 and 9 return the low and high count words. Writes to them leave the count unchanged.
- R8: Reads of every offset not named in R2, R3, R6, R7 or R9 return zero, and writes to them change no state.
- R9: Control bits 1 and 2 are stored and read back, but have no effect on counting.
- R10: A wide read at offset a returns word a in bits [31:0] and word a+1 in bits [63:32]. A wide write at offset 2 loads the full 64-bit count; at any other offset only the lower word is written.
- R11: After reset, counting is off, the count is 0, the active entry is 0, entry 0 holds frequency RESET_FREQ with step RESET_INC, and all other entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_wide | input | 1 | 64-bit access covering two adjacent words |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 64 | Write data; lower word used for narrow access |
| bus_rdata | output | 64 | Combinational read data, zero when not strobed |
| count_o | output | 64 | Current count |
| freq_o | output | 24 | Frequency value of the active entry |
| entry_o | output | IDX_W | Index of the active entry |

## Verification
The assertions assume that a count load never lands on the same clock as a mode switch taking effect. They also assume that loads happen only while counting is off, because a load during counting has no defined result. The stimulus keeps to both rules: every load and every switch request is issued with the run bit cleared, and each request is followed by an idle clock before the next access. Steps are held small and distinct across the entries, so each switch in the sweep exercises a different pair of old and new steps in the realignment arithmetic.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int CNT_W  = 64;
    localparam int WORD_W = 32;
    localparam int INC_W  = 8;
    localparam int FRQ_W  = 24;

    localparam int OFS_CTRL    = 0;
    localparam int OFS_STAT    = 1;
    localparam int OFS_CNT_LO  = 2;
    localparam int OFS_CNT_HI  = 3;
    localparam int OFS_VIEW_LO = 8;
    localparam int OFS_VIEW_HI = 9;
    localparam int TBL_BASE    = 16;

    localparam int BIT_RUN   = 0;
    localparam int BIT_HDBG  = 1;
    localparam int BIT_SCALE = 2;
    localparam int BIT_CHG   = 3;
    localparam int SEL_LSB   = 16;
    localparam int SEL_W     = 16;

    typedef struct packed {
        logic [FRQ_W-1:0] freq;
        logic [INC_W-1:0] inc;
    } mode_t;

    typedef struct packed {
        logic scale;
        logic hdbg;
        logic run;
    } ctl_t;

    function automatic logic [INC_W-1:0] wider_step(input logic [INC_W-1:0] a,
                                                   input logic [INC_W-1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sc_table.sv
module sc_table
    import sc_pkg::*;
#(
    parameter int    DEPTH     = 8,
    parameter int    IDX_W     = 3,
    parameter mode_t RST_ENTRY = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wa_i,
    input  mode_t            wd_i,
    input  logic [IDX_W-1:0] ra0_i,
    input  logic [IDX_W-1:0] ra1_i,
    input  logic [IDX_W-1:0] rs_i,
    output mode_t            rd0_o,
    output mode_t            rd1_o,
    output mode_t            rs_o
);
    localparam int SLOTS = DEPTH - 1;

    mode_t slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= (g == 0) ? RST_ENTRY : '0;
            else if (we_i && (int'(wa_i) == g))
                slot_q[g] <= wd_i;
        end
    end

    function automatic mode_t pick(input logic [IDX_W-1:0] idx);
        mode_t r;
        r = '0;
        for (int i = 0; i < SLOTS; i++)
            if (int'(idx) == i) r = slot_q[i];
        return r;
    endfunction

    always_comb begin
        rd0_o = pick(ra0_i);
        rd1_o = pick(ra1_i);
        rs_o  = pick(rs_i);
    end
endmodule

// File: rtl/sc_counter.sv
module sc_counter
    import sc_pkg::*;
#(
    parameter logic [INC_W-1:0] RESET_INC = 8'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             switch_i,
    input  logic [INC_W-1:0] new_inc_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] count_q;
    logic [INC_W-1:0] inc_q;
    logic [INC_W-1:0] span;
    logic [CNT_W-1:0] rem;

    always_comb begin
        span = wider_step(inc_q, new_inc_i);
        rem  = (span == '0) ? '0 : (count_q % CNT_W'(span));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            inc_q   <= RESET_INC;
        end else begin
            if (switch_i)
                inc_q <= new_inc_i;
            if (wr_lo_i || wr_hi_i) begin
                if (wr_lo_i) count_q[WORD_W-1:0]     <= wdata_i[WORD_W-1:0];
                if (wr_hi_i) count_q[CNT_W-1:WORD_W] <= wdata_i[CNT_W-1:WORD_W];
            end else if (switch_i) begin
                count_q <= count_q + rem;
            end else if (run_i) begin
                count_q <= count_q + CNT_W'(inc_q);
            end
        end
    end

    assign count_o = count_q;

    assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !wr_lo_i && !wr_hi_i && !switch_i) |=> $stable(count_q));

    assert_step_add_R5: assert property (@(posedge clk) disable iff (rst)
        (run_i && !wr_lo_i && !wr_hi_i && !switch_i)
        |=> (count_q == $past(count_q) + CNT_W'($past(inc_q))));

    assert_step_swap_R4: assert property (@(posedge clk) disable iff (rst)
        switch_i |=> (inc_q == $past(new_inc_i)));

    assert_low_load_R6: assert property (@(posedge clk) disable iff (rst)
        wr_lo_i |=> (count_q[WORD_W-1:0] == $past(wdata_i[WORD_W-1:0])));
endmodule

// File: rtl/sc_regs.sv
module sc_regs
    import sc_pkg::*;
#(
    parameter int               DEPTH      = 8,
    parameter int               ADDR_W     = 6,
    parameter int               IDX_W      = 3,
    parameter logic [FRQ_W-1:0] RESET_FREQ = 24'd100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  count_i,
    input  mode_t             tbl_rd0_i,
    input  mode_t             tbl_rd1_i,
    input  mode_t             tbl_sel_i,
    output logic [IDX_W-1:0]  tbl_ra0_o,
    output logic [IDX_W-1:0]  tbl_ra1_o,
    output logic [IDX_W-1:0]  tbl_rs_o,
    output logic              tbl_we_o,
    output logic [IDX_W-1:0]  tbl_wa_o,
    output mode_t             tbl_wd_o,
    output logic              run_o,
    output logic              cnt_wr_lo_o,
    output logic              cnt_wr_hi_o,
    output logic [CNT_W-1:0]  cnt_wd_o,
    output logic              switch_o,
    output logic [IDX_W-1:0]  act_idx_o,
    output logic [FRQ_W-1:0]  act_freq_o
);
    localparam int LAST = DEPTH - 1;

    ctl_t              ctl_q;
    logic              pend_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic [IDX_W-1:0]  act_idx_q;
    logic [FRQ_W-1:0]  act_freq_q;

    logic [ADDR_W-1:0] a0, a1;
    logic              wr, ctl_wr, chg_ok;
    logic [SEL_W-1:0]  sel_full;
    logic [WORD_W-1:0] lane0, lane1;

    function automatic logic in_tbl(input logic [ADDR_W-1:0] a);
        return (int'(a) >= TBL_BASE) && (int'(a) < TBL_BASE + LAST);
    endfunction

    function automatic logic [IDX_W-1:0] tbl_idx(input logic [ADDR_W-1:0] a);
        return IDX_W'(int'(a) - TBL_BASE);
    endfunction

    function automatic logic [WORD_W-1:0] word_at(input logic [ADDR_W-1:0] a,
                                                 input mode_t tw);
        logic [WORD_W-1:0] w;
        w = '0;
        case (int'(a))
            OFS_CTRL: begin
                w[BIT_RUN]   = ctl_q.run;
                w[BIT_HDBG]  = ctl_q.hdbg;
                w[BIT_SCALE] = ctl_q.scale;
            end
            OFS_STAT: begin
                w[0]                 = pend_q;
                w[SEL_LSB +: IDX_W]  = act_idx_q;
            end
            OFS_CNT_LO, OFS_VIEW_LO: w = count_i[WORD_W-1:0];
            OFS_CNT_HI, OFS_VIEW_HI: w = count_i[CNT_W-1:WORD_W];
            default: if (in_tbl(a)) w = tw;
        endcase
        return w;
    endfunction

    always_comb begin
        a0        = bus_addr;
        a1        = bus_addr + ADDR_W'(1);
        tbl_ra0_o = tbl_idx(a0);
        tbl_ra1_o = tbl_idx(a1);
        tbl_rs_o  = pend_idx_q;
        lane0     = word_at(a0, tbl_rd0_i);
        lane1     = word_at(a1, tbl_rd1_i);
        bus_rdata = '0;
        if (bus_en && !bus_we)
            bus_rdata = {bus_wide ? lane1 : '0, lane0};

        wr       = bus_en && bus_we;
        ctl_wr   = wr && (int'(a0) == OFS_CTRL);
        sel_full = bus_wdata[SEL_LSB +: SEL_W];
        chg_ok   = bus_wdata[BIT_CHG] && (int'(sel_full) < LAST);

        cnt_wr_lo_o = wr && (int'(a0) == OFS_CNT_LO);
        cnt_wr_hi_o = wr && ((int'(a0) == OFS_CNT_HI) ||
                             (bus_wide && (int'(a0) == OFS_CNT_LO)));
        cnt_wd_o    = {(int'(a0) == OFS_CNT_HI) ? bus_wdata[WORD_W-1:0]
                                                : bus_wdata[CNT_W-1:WORD_W],
                       bus_wdata[WORD_W-1:0]};

        tbl_we_o = wr && in_tbl(a0);
        tbl_wa_o = tbl_idx(a0);
        tbl_wd_o = mode_t'(bus_wdata[WORD_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            act_idx_q  <= '0;
            act_freq_q <= RESET_FREQ;
        end else begin
            pend_q <= ctl_wr && chg_ok;
            if (ctl_wr) begin
                ctl_q.run   <= bus_wdata[BIT_RUN];
                ctl_q.hdbg  <= bus_wdata[BIT_HDBG];
                ctl_q.scale <= bus_wdata[BIT_SCALE];
                if (chg_ok) pend_idx_q <= IDX_W'(sel_full);
            end
            if (pend_q) begin
                act_idx_q  <= pend_idx_q;
                act_freq_q <= tbl_sel_i.freq;
            end
        end
    end

    assign run_o      = ctl_q.run;
    assign switch_o   = pend_q;
    assign act_idx_o  = act_idx_q;
    assign act_freq_o = act_freq_q;

    assert_entry_legal_R2: assert property (@(posedge clk) disable iff (rst)
        int'(act_idx_q) < LAST);

    assert_switch_lands_R3: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> (act_idx_q == $past(pend_idx_q)) &&
                   (act_freq_q == $past(tbl_sel_i.freq)));

    assert_pend_one_clock_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !ctl_wr) |=> !pend_q);

    assert_idle_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_en |-> (bus_rdata == '0));
endmodule

// File: rtl/tick_base_counter.sv
module tick_base_counter
    import sc_pkg::*;
#(
    parameter int               DEPTH      = 8,
    parameter int               ADDR_W     = 6,
    parameter logic [FRQ_W-1:0] RESET_FREQ = 24'd100,
    parameter logic [INC_W-1:0] RESET_INC  = 8'd1,
    localparam int              IDX_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic [63:0]       count_o,
    output logic [23:0]       freq_o,
    output logic [IDX_W-1:0]  entry_o
);
    localparam mode_t RST_ENTRY = '{freq: RESET_FREQ, inc: RESET_INC};

    mode_t             tbl_rd0, tbl_rd1, tbl_sel, tbl_wd;
    logic [IDX_W-1:0]  tbl_ra0, tbl_ra1, tbl_rs, tbl_wa;
    logic              tbl_we, run, wr_lo, wr_hi, switch_now;
    logic [CNT_W-1:0]  cnt_wd, count;

    sc_regs #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .RESET_FREQ(RESET_FREQ)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count_i(count),
        .tbl_rd0_i(tbl_rd0), .tbl_rd1_i(tbl_rd1), .tbl_sel_i(tbl_sel),
        .tbl_ra0_o(tbl_ra0), .tbl_ra1_o(tbl_ra1), .tbl_rs_o(tbl_rs),
        .tbl_we_o(tbl_we), .tbl_wa_o(tbl_wa), .tbl_wd_o(tbl_wd),
        .run_o(run), .cnt_wr_lo_o(wr_lo), .cnt_wr_hi_o(wr_hi), .cnt_wd_o(cnt_wd),
        .switch_o(switch_now), .act_idx_o(entry_o), .act_freq_o(freq_o)
    );

    sc_table #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .RST_ENTRY(RST_ENTRY)
    ) u_table (
        .clk(clk), .rst(rst),
        .we_i(tbl_we), .wa_i(tbl_wa), .wd_i(tbl_wd),
        .ra0_i(tbl_ra0), .ra1_i(tbl_ra1), .rs_i(tbl_rs),
        .rd0_o(tbl_rd0), .rd1_o(tbl_rd1), .rs_o(tbl_sel)
    );

    sc_counter #(
        .RESET_INC(RESET_INC)
    ) u_counter (
        .clk(clk), .rst(rst),
        .run_i(run), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(cnt_wd),
        .switch_i(switch_now), .new_inc_i(tbl_sel.inc),
        .count_o(count)
    );

    assign count_o = count;
endmodule

// File: tb/tick_base_counter_test.sv
`timescale 1ns/1ps
module tick_base_counter_test;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_en = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [63:0]       bus_wdata = '0;
    logic [63:0]       bus_rdata, count_o;
    logic [23:0]       freq_o;
    logic [IDX_W-1:0]  entry_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  m_inc  [DEPTH];
    logic [23:0] m_freq [DEPTH];
    logic [7:0]  cur_inc;

    always #2 clk = ~clk;

    tick_base_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count_o(count_o), .freq_o(freq_o), .entry_o(entry_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [63:0] d, input bit wide);
        bus_en = 1; bus_we = 1; bus_wide = wide;
        bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0; bus_wide = 0;
    endtask

    task automatic bus_rd(input int a, input bit wide, output logic [63:0] d);
        bus_en = 1; bus_we = 0; bus_wide = wide; bus_addr = ADDR_W'(a);
        #0.5;
        d = bus_rdata;
        bus_en = 0; bus_wide = 0;
    endtask

    task automatic expect_rd(input int a, input bit wide, input logic [63:0] exp,
                             input string tag);
        logic [63:0] d;
        bus_rd(a, wide, d);
        check(d == exp, tag, d, exp);
    endtask

    function automatic logic [63:0] realign(input logic [63:0] c,
                                            input logic [7:0] o, input logic [7:0] n);
        logic [7:0] m;
        m = (o > n) ? o : n;
        return (m == 0) ? c : c + (c % 64'(m));
    endfunction

    task automatic run_for(input int n);
        bus_wr(0, 64'h1, 0);
        repeat (n) @(negedge clk);
        bus_wr(0, 64'h0, 0);
    endtask

    task automatic request(input int idx);
        bus_wr(0, (64'(idx) << 16) | 64'h8, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] c, e, d;
        repeat (3) @(negedge clk);
        rst = 0;

        // R11 reset state
        expect_rd(2, 1, 64'h0, "R11 count");
        check(entry_o == 0, "R11 entry", 64'(entry_o), 0);
        check(freq_o == 24'd100, "R11 freq", 64'(freq_o), 64'd100);
        expect_rd(0, 0, 64'h0, "R11 ctrl");
        expect_rd(16, 0, 64'h6401, "R11 entry0");
        expect_rd(17, 0, 64'h0, "R11 entry1");

        // R1 hold while off
        repeat (10) @(negedge clk);
        check(count_o == 0, "R1 hold", count_o, 0);

        // fill table (R2)
        m_inc[0] = 8'd1; m_freq[0] = 24'd100;
        for (int i = 1; i < DEPTH - 1; i++) begin
            m_inc[i]  = 8'((i * 3) % 7 + 1);
            m_freq[i] = 24'(1000 + i);
            bus_wr(16 + i, 64'({m_freq[i], m_inc[i]}), 0);
        end
        for (int i = 1; i < DEPTH - 1; i++)
            expect_rd(16 + i, 0, 64'({m_freq[i], m_inc[i]}), "R2 table readback");

        // R2 terminator
        bus_wr(16 + DEPTH - 1, 64'hFFFF_FFFF, 0);
        expect_rd(16 + DEPTH - 1, 0, 64'h0, "R2 terminator read");
        request(DEPTH - 1);
        @(negedge clk);
        check(entry_o == 0, "R2 terminator request", 64'(entry_o), 0);
        request(DEPTH + 1);
        @(negedge clk);
        check(entry_o == 0, "R2 out of range request", 64'(entry_o), 0);

        // R5 counting with entry 0
        run_for(20);
        check(count_o == 64'd21, "R5 step one", count_o, 64'd21);
        cur_inc = m_inc[0];

        // R4/R3/R5 sweep across entries
        for (int j = 1; j < DEPTH - 1; j++) begin
            c = 64'h0000_0001_0000_0000 + 64'(j * 37 + 11);
            bus_wr(2, c, 1);
            expect_rd(2, 1, c, "R10 wide load");
            request(j);
            check(entry_o == IDX_W'(j - 1 < 1 ? 0 : j - 1) || j == 1 ? entry_o != IDX_W'(j) : 1'b0,
                  "R3 entry before switch", 64'(entry_o), 64'(j - 1));
            expect_rd(1, 0, {32'h0, 16'(j - 1), 16'h1}, "R3 pending status");
            @(negedge clk);
            check(entry_o == IDX_W'(j), "R3 entry", 64'(entry_o), 64'(j));
            check(freq_o == m_freq[j], "R3 freq", 64'(freq_o), 64'(m_freq[j]));
            expect_rd(1, 0, {32'h0, 16'(j), 16'h0}, "R3 status");
            e = realign(c, cur_inc, m_inc[j]);
            check(count_o == e, "R4 realign", count_o, e);
            cur_inc = m_inc[j];
            run_for(9 + j);
            e = e + 64'(10 + j) * 64'(cur_inc);
            check(count_o == e, "R5 step sweep", count_o, e);
        end

        // R5 carry across word boundary
        bus_wr(2, 64'hFFFF_FFF0, 1);
        run_for(7);
        e = 64'hFFFF_FFF0 + 64'(8) * 64'(cur_inc);
        check(count_o == e, "R5 carry", count_o, e);

        // R6 narrow loads
        bus_wr(2, 64'h1234_5678, 0);
        bus_wr(3, 64'h0000_00AB, 0);
        expect_rd(2, 1, 64'h0000_00AB_1234_5678, "R6 narrow loads");

        // R7 view read-only
        bus_wr(8, 64'hDEAD_BEEF, 0);
        bus_wr(8, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        bus_wr(9, 64'h5555_5555, 0);
        expect_rd(8, 1, 64'h0000_00AB_1234_5678, "R7 view");
        check(count_o == 64'h0000_00AB_1234_5678, "R7 writes ignored", count_o,
              64'h0000_00AB_1234_5678);

        // R8 unimplemented offsets
        for (int a = 0; a < 64; a++) begin
            if (!(a <= 3 || a == 8 || a == 9 || (a >= 16 && a < 16 + DEPTH - 1))) begin
                bus_wr(a, 64'hFFFF_FFFF_FFFF_FFFF, 0);
                expect_rd(a, 0, 64'h0, "R8 unimplemented read");
            end
        end
        expect_rd(0, 0, 64'h0, "R8 ctrl untouched");
        check(count_o == 64'h0000_00AB_1234_5678, "R8 count untouched", count_o,
              64'h0000_00AB_1234_5678);
        check(entry_o == IDX_W'(DEPTH - 2), "R8 entry untouched", 64'(entry_o), 64'(DEPTH - 2));

        // R9 inert control bits
        bus_wr(0, 64'h6, 0);
        expect_rd(0, 0, 64'h6, "R9 readback");
        repeat (5) @(negedge clk);
        check(count_o == 64'h0000_00AB_1234_5678, "R9 no count when off", count_o,
              64'h0000_00AB_1234_5678);
        c = count_o;
        bus_wr(0, 64'h7, 0);
        repeat (4) @(negedge clk);
        bus_wr(0, 64'h6, 0);
        e = c + 64'(5) * 64'(cur_inc);
        check(count_o == e, "R9 counts normally", count_o, e);

        // R10 wide read and wide write outside count pair
        expect_rd(17, 1, {32'({m_freq[2], m_inc[2]}), 32'({m_freq[1], m_inc[1]})},
                  "R10 wide table read");
        bus_wr(17, 64'h0000_0000_0000_3302, 1);
        expect_rd(17, 1, {32'({m_freq[2], m_inc[2]}), 32'h3302}, "R10 upper lane ignored");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule